// File: doc/BRIEF.md
# Floating-Point Status Word Register

This block stores the status word shared by a set of floating-point arithmetic units. The word holds two fields. The first is a two-bit rounding-mode field, which is fed back to the units to set how they round. The second is a six-bit field of sticky exception flags: invalid operation, overflow, underflow, inexact, input flushed to zero and output flushed to zero.

Each arithmetic unit owns one update port. A port carries a commit strobe and a six-bit flag vector. The strobe is high in the cycle the unit writes its destination result, and only when that operation's guard was true. The flags of every committed port are ORed into the stored flags at the next clock edge. No operation can clear a flag.

Software changes the word only through an explicit write port, which loads the whole word and is the only way to clear flags. If a write and committed updates land in the same cycle, the written value is loaded and the committed flags are ORed on top of it.

Top module: `fpsw_reg`

## Requirements
- R1: While rst_n is low, all six flags read 0 and the rounding mode reads 0 (round to nearest even). Encodings: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R2: When a port's commit strobe is high, every flag bit set in that port's vector is set in the stored flags after the next rising clock edge. Port p's vector is upd_flags[6p+5:6p].
- R3: A port whose commit strobe is low contributes nothing, whatever its flag vector holds.
- R4: When several ports commit in the same cycle, the stored flags become the OR of the old flags and the vectors of all committing ports.
- R5: Without a software write, no stored flag ever goes from 1 to 0.
- R6: A software write with no committed update loads the whole word, so that both flags and rounding mode equal the written value after the edge.
- R7: A software write in the same cycle as committed updates loads the written rounding mode, and the flags become the written flags ORed with the committed vectors.
- R8: The rounding mode changes only on a software write. Flag updates never alter it.
- R9: status_word presents the flags in bits [5:0] and the rounding mode in bits [7:6]. Flag order from bit 0 upward is invalid, overflow, underflow, inexact, input-flushed, output-flushed. The flags and round_mode outputs equal those fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_commit | input | NUM_PORTS | Commit strobe for each update port |
| upd_flags | input | 6*NUM_PORTS | Flag vectors; port p in bits [6p+5:6p] |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 8 | Whole status word to load |
| status_word | output | 8 | Stored word: {rounding mode, flags} |
| round_mode | output | 2 | Rounding mode to the arithmetic units |
| flags | output | 6 | Sticky exception flags |

## Verification
Every cycle, the assertions check four things. Flags never drop without a write. A committed port's bits are present one cycle later. Idle cycles leave the word unchanged. The rounding mode moves only on a write, and a write lands both its mode and its flags. Only the bench's scenarios can show that the stored result is exactly the OR of the committed vectors and no more. The same holds for the field layout of the status word and for the value that results when a write collides with several commits. The bench covers these by sweeping every commit mask, every written word and every port and flag bit.

// File: rtl/fpsw_pkg.sv
package fpsw_pkg;
    localparam int FLAG_W = 6;
    localparam int RM_W   = 2;
    localparam int WORD_W = FLAG_W + RM_W;

    // flag bit positions inside the flag field
    localparam int FL_INVALID   = 0;
    localparam int FL_OVERFLOW  = 1;
    localparam int FL_UNDERFLOW = 2;
    localparam int FL_INEXACT   = 3;
    localparam int FL_IN_FLUSH  = 4;
    localparam int FL_OUT_FLUSH = 5;

    typedef enum logic [RM_W-1:0] {
        RM_NEAREST_EVEN = 2'd0,
        RM_TOWARD_ZERO  = 2'd1,
        RM_TOWARD_POS   = 2'd2,
        RM_TOWARD_NEG   = 2'd3
    } rmode_e;

    typedef logic [FLAG_W-1:0] flags_t;

    // packed: rounding mode occupies the upper bits of the word
    typedef struct packed {
        rmode_e rmode;
        flags_t flags;
    } fpsw_t;
endpackage

// File: rtl/fpsw_port_merge.sv
module fpsw_port_merge
    import fpsw_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [NUM_PORTS-1:0]        commit,
    input  logic [NUM_PORTS*FLAG_W-1:0] flags_flat,
    output flags_t                      merged
);
    flags_t gated [NUM_PORTS];

    // gate each port's vector by its own strobe
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_gate
        assign gated[p] = flags_flat[p*FLAG_W +: FLAG_W] & {FLAG_W{commit[p]}};
    end

    always_comb begin
        merged = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            merged = merged | gated[p];
        end
    end
endmodule

// File: rtl/fpsw_next.sv
module fpsw_next
    import fpsw_pkg::*;
(
    input  fpsw_t  cur,
    input  logic   wr_en,
    input  fpsw_t  wr_word,
    input  flags_t merged,
    output fpsw_t  nxt
);
    fpsw_t base;

    always_comb begin
        // explicit write replaces the word; op flags land on top of it
        base       = wr_en ? wr_word : cur;
        nxt.rmode  = base.rmode;
        nxt.flags  = base.flags | merged;
    end
endmodule

// File: rtl/fpsw_reg.sv
module fpsw_reg
    import fpsw_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        upd_commit,
    input  logic [NUM_PORTS*FLAG_W-1:0] upd_flags,
    input  logic                        sw_wr_en,
    input  logic [WORD_W-1:0]           sw_wr_data,
    output logic [WORD_W-1:0]           status_word,
    output logic [RM_W-1:0]             round_mode,
    output logic [FLAG_W-1:0]           flags
);
    localparam fpsw_t RESET_WORD = '{rmode: RM_NEAREST_EVEN, flags: '0};

    fpsw_t  state_q;
    fpsw_t  state_d;
    flags_t merged;
    fpsw_t  wr_word;

    assign wr_word = fpsw_t'(sw_wr_data);

    fpsw_port_merge #(.NUM_PORTS(NUM_PORTS)) u_merge (
        .commit     (upd_commit),
        .flags_flat (upd_flags),
        .merged     (merged)
    );

    fpsw_next u_next (
        .cur     (state_q),
        .wr_en   (sw_wr_en),
        .wr_word (wr_word),
        .merged  (merged),
        .nxt     (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RESET_WORD;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_word = state_q;
    assign round_mode  = state_q.rmode;
    assign flags       = state_q.flags;
endmodule

// File: rtl/fpsw_reg_chk.sv
module fpsw_reg_chk
    import fpsw_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PORTS-1:0]        upd_commit,
    input logic [NUM_PORTS*FLAG_W-1:0] upd_flags,
    input logic                        sw_wr_en,
    input logic [WORD_W-1:0]           sw_wr_data,
    input logic [RM_W-1:0]             round_mode,
    input logic [FLAG_W-1:0]           flags
);
    // R1: reset value seen at the edge after reset was sampled low
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && round_mode == RM_NEAREST_EVEN));

    // R5: sticky flags without a write
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en |=> ((flags & $past(flags)) == $past(flags)));

    // R3: no commit and no write leaves the flags alone
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && upd_commit == '0) |=> $stable(flags));

    // R8: rounding mode moves only on a write
    a_r8_rmode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr_en |=> $stable(round_mode));

    // R6 / R7: a write lands its rounding mode and at least its flags
    a_r6_write_rmode: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (round_mode == $past(sw_wr_data[WORD_W-1:FLAG_W])));
    a_r7_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> ((flags & $past(sw_wr_data[FLAG_W-1:0]))
                      == $past(sw_wr_data[FLAG_W-1:0])));

    // R2: a committed port's bits show up one cycle later
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        a_r2_commit_set: assert property (@(posedge clk) disable iff (!rst_n)
            upd_commit[p] |=> ((flags & $past(upd_flags[p*FLAG_W +: FLAG_W]))
                               == $past(upd_flags[p*FLAG_W +: FLAG_W])));
    end
endmodule

bind fpsw_reg fpsw_reg_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_commit (upd_commit),
    .upd_flags  (upd_flags),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .round_mode (round_mode),
    .flags      (flags)
);

// File: tb/fpsw_reg_tb.sv
`timescale 1ns/1ps
module fpsw_reg_tb;
    localparam int NP = 4;
    localparam int FW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   upd_commit = '0;
    logic [NP*FW-1:0] upd_flags = '0;
    logic            sw_wr_en = 1'b0;
    logic [7:0]      sw_wr_data = '0;
    logic [7:0]      status_word;
    logic [1:0]      round_mode;
    logic [5:0]      flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fpsw_reg #(.NUM_PORTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .upd_commit(upd_commit), .upd_flags(upd_flags),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .status_word(status_word), .round_mode(round_mode), .flags(flags)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, return at next negedge with inputs idle
    task automatic step(input logic [NP-1:0] c, input logic [NP*FW-1:0] f,
                        input logic w, input logic [7:0] d);
        @(negedge clk);
        upd_commit = c; upd_flags = f; sw_wr_en = w; sw_wr_data = d;
        @(negedge clk);
        upd_commit = '0; upd_flags = '0; sw_wr_en = 1'b0; sw_wr_data = '0;
    endtask

    function automatic logic [5:0] pat(input int m, input int p);
        return 6'((m * 7 + p * 11 + 5) % 64);
    endfunction

    function automatic logic [NP*FW-1:0] pack(input int m);
        logic [NP*FW-1:0] v = '0;
        for (int p = 0; p < NP; p++) v[p*FW +: FW] = pat(m, p);
        return v;
    endfunction

    function automatic logic [5:0] or_of(input logic [NP-1:0] c, input int m);
        logic [5:0] r = '0;
        for (int p = 0; p < NP; p++) if (c[p]) r = r | pat(m, p);
        return r;
    endfunction

    task automatic chk_all(input string req, input logic [1:0] rm, input logic [5:0] fl);
        chk(req, {6'd0, round_mode}, {6'd0, rm});
        chk(req, {2'd0, flags}, {2'd0, fl});
        chk({req, "/R9"}, status_word, {rm, fl});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1", 2'd0, 6'd0);
        rst_n = 1'b1;

        // R2: each port, each flag bit, alone
        for (int p = 0; p < NP; p++) begin
            for (int b = 0; b < FW; b++) begin
                step('0, '0, 1'b1, 8'h80);
                step(NP'(1 << p), (NP*FW)'(1) << (p*FW + b), 1'b0, 8'h00);
                chk_all("R2", 2'd2, 6'(1 << b));
            end
        end

        // R3: uncommitted ports carry all ones, nothing lands
        step('0, '0, 1'b1, 8'h40);
        for (int p = 0; p < NP; p++) begin
            step(~NP'(1 << p), {NP*FW{1'b0}} | ((NP*FW)'(6'h3F) << (p*FW)), 1'b0, 8'h00);
            chk_all("R3", 2'd1, 6'd0);
        end
        step('0, '1, 1'b0, 8'h00);
        chk_all("R3", 2'd1, 6'd0);

        // R4: every commit mask on top of a seeded old value
        for (int m = 0; m < (1 << NP); m++) begin
            logic [5:0] old = 6'((m * 13) % 64) & 6'h15;
            step('0, '0, 1'b1, {2'd3, old});
            step(NP'(m), pack(m), 1'b0, 8'h00);
            chk_all("R4", 2'd3, old | or_of(NP'(m), m));
        end

        // R5 / R8: set everything, then idle and empty commits
        step('0, '0, 1'b1, 8'h7F);
        for (int k = 0; k < 8; k++) begin
            step(NP'(k), '0, 1'b0, 8'h00);
            chk_all("R5", 2'd1, 6'h3F);
        end
        step('1, pack(3), 1'b0, 8'h00);
        chk_all("R8", 2'd1, 6'h3F);

        // R6: every written word, no updates
        for (int d = 0; d < 256; d++) begin
            step('0, '0, 1'b1, 8'(d));
            chk_all("R6", 2'(d >> 6), 6'(d));
        end

        // R7: write colliding with commits
        for (int d = 0; d < 256; d += 17) begin
            for (int m = 1; m < (1 << NP); m += 3) begin
                step(NP'(m), pack(m + d), 1'b1, 8'(d));
                chk_all("R7", 2'(d >> 6), 6'(d) | or_of(NP'(m), m + d));
            end
        end

        // R1 again: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1", 2'd0, 6'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule